// File: doc/BRIEF.md
# Masked Streaming Pattern Comparator Array

This block searches a serial data stream for stored bit patterns. It has a set of parallel lanes. Each lane keeps a sliding window of the most recent stream bits in a shift register, a stored target in a pattern register and a don't-care set in a mask register. Every symbol on `sym_in` carries one bit per lane. Each shift strobe pushes bit i of the symbol into lane i and drops that lane's oldest bit. Each lane keeps comparing its window with its target and ignores the positions that its mask excludes. It reports a hit on an active-low output. An active-low global output combines all lanes so that a host can be interrupted on any hit.

The lanes have no separate load ports. To program a target, software shifts the target into the window and then pulses the pattern-load strobe, which copies the whole window into the pattern register. The mask is programmed the same way with the mask-load strobe. The oldest bit of each lane is presented on a tap output, so the stream leaves the block exactly one window length of shifts after it entered. Several blocks can then be chained end to end to search for longer patterns.

Everything is synchronous to `clk`, with an active-low reset. The match outputs are driven combinationally from the registers, so they describe the window as it stands after the most recent edge.

Top module: `pcmp_array`

## Requirements
- R1: On a clock edge with `shift_en` high, bit i of `sym_in` enters position 0 of lane i's window, every other position moves up by one, and the oldest bit is discarded.
- R2: A lane hits when every window bit that is not masked equals the pattern bit at the same position.
- R3: A mask bit of 1 removes that position from the comparison. A lane whose mask is all ones always hits.
- R4: On an edge with `pat_load` high, the lane's pattern register receives the window as it was before that edge, including when `shift_en` is high in the same cycle.
- R5: On an edge with `mask_load` high, the lane's mask register receives the window as it was before that edge, including when `shift_en` is high in the same cycle.
- R6: `lane_hit_n[i]` is 0 when lane i hits and 1 when it does not.
- R7: `any_hit_n` is 0 exactly when at least one bit of `lane_hit_n` is 0.
- R8: `tap_out[i]` shows the oldest window bit of lane i, so a bit shifted in appears there after exactly DEPTH shifts.
- R9: Reset clears the window, pattern and mask of every lane. Right after reset every lane hits and every tap reads 0.
- R10: On an edge with all three strobes low, no register changes, so the taps and match outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all registers |
| shift_en | input | 1 | Shift one symbol into the windows this cycle |
| pat_load | input | 1 | Copy each window into its pattern register |
| mask_load | input | 1 | Copy each window into its mask register |
| sym_in | input | LANES | Stream symbol, bit i feeds lane i |
| tap_out | output | LANES | Oldest window bit of each lane, for chaining |
| lane_hit_n | output | LANES | Per-lane match, active low |
| any_hit_n | output | 1 | Global match, low when any lane hits |

## Verification
The bench builds the block with its default parameters: seven lanes and a window of 70 bits. With these values the full tap latency of 70 shifts can be observed, and one symbol pattern can make one lane hit while the other six miss. The full-window load sequences stay short enough to repeat for a wildcard mask, an all-ones mask and a load that falls in the same cycle as a shift.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;

    localparam int DEF_LANES = 7;
    localparam int DEF_DEPTH = 70;

    typedef struct packed {
        logic shift;
        logic pat;
        logic msk;
    } pcmp_ctl_t;

endpackage

// File: rtl/pcmp_lane.sv
module pcmp_lane
    import pcmp_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pcmp_ctl_t ctl,
    input  logic      din,
    output logic      tap_out,
    output logic      hit_n
);

    localparam int TOP = DEPTH - 1;

    logic [TOP:0] win_q;
    logic [TOP:0] pat_q;
    logic [TOP:0] msk_q;
    logic [TOP:0] diff;

    // window register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (ctl.shift) begin
            win_q <= {win_q[TOP-1:0], din};
        end
    end

    // pattern and mask copy the pre-edge window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q <= '0;
            msk_q <= '0;
        end else begin
            if (ctl.pat) pat_q <= win_q;
            if (ctl.msk) msk_q <= win_q;
        end
    end

    always_comb begin
        diff    = (win_q ^ pat_q) & ~msk_q;
        hit_n   = |diff;
        tap_out = win_q[TOP];
    end

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.shift && !ctl.pat && !ctl.msk |=> $stable(win_q) && $stable(pat_q) && $stable(msk_q));

    a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.shift |=> win_q[0] == $past(din));

    a_r8_tap_age: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.shift |=> tap_out == $past(win_q[TOP-1]));

    a_r4_pat_copy: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pat |=> pat_q == $past(win_q));

    a_r5_msk_copy: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.msk |=> msk_q == $past(win_q));

    a_r3_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (&msk_q) |-> !hit_n);

    a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (win_q == '0) && (pat_q == '0) && (msk_q == '0));

endmodule

// File: rtl/pcmp_merge.sv
module pcmp_merge #(
    parameter int LANES = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_hit_n,
    output logic             any_hit_n
);

    always_comb begin
        any_hit_n = &lane_hit_n;
    end

    a_r7_any_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~lane_hit_n) != 0) |-> !any_hit_n);

    a_r7_none_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~lane_hit_n) == 0) |-> any_hit_n);

endmodule

// File: rtl/pcmp_array.sv
module pcmp_array
    import pcmp_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int DEPTH = DEF_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             pat_load,
    input  logic             mask_load,
    input  logic [LANES-1:0] sym_in,
    output logic [LANES-1:0] tap_out,
    output logic [LANES-1:0] lane_hit_n,
    output logic             any_hit_n
);

    pcmp_ctl_t ctl;

    always_comb begin
        ctl.shift = shift_en;
        ctl.pat   = pat_load;
        ctl.msk   = mask_load;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pcmp_lane #(
            .DEPTH (DEPTH)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl     (ctl),
            .din     (sym_in[g]),
            .tap_out (tap_out[g]),
            .hit_n   (lane_hit_n[g])
        );
    end

    pcmp_merge #(
        .LANES (LANES)
    ) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_hit_n (lane_hit_n),
        .any_hit_n  (any_hit_n)
    );

endmodule

// File: tb/pcmp_array_bench.sv
module pcmp_array_bench;

    localparam int L = 7;
    localparam int D = 70;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_en = 1'b0;
    logic         pat_load = 1'b0;
    logic         mask_load = 1'b0;
    logic [L-1:0] sym_in = '0;
    logic [L-1:0] tap_out;
    logic [L-1:0] lane_hit_n;
    logic         any_hit_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [L-1:0] tap;
        logic [L-1:0] hit;
        logic         any;
        string        tag;
    } exp_t;

    exp_t sb[$];

    // reference state built from the requirements
    logic [D-1:0] m_win [L];
    logic [D-1:0] m_pat [L];
    logic [D-1:0] m_msk [L];

    always #10 clk = ~clk;

    pcmp_array #(.LANES(L), .DEPTH(D)) u_pcmp_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .pat_load   (pat_load),
        .mask_load  (mask_load),
        .sym_in     (sym_in),
        .tap_out    (tap_out),
        .lane_hit_n (lane_hit_n),
        .any_hit_n  (any_hit_n)
    );

    function automatic exp_t predict(string tag);
        exp_t e;
        e.tag = tag;
        for (int i = 0; i < L; i++) begin
            e.tap[i] = m_win[i][D-1];
            e.hit[i] = |((m_win[i] ^ m_pat[i]) & ~m_msk[i]);
        end
        e.any = (e.hit == '1);
        return e;
    endfunction

    // driver: applies one cycle and pushes the expected result
    task automatic step(input logic [L-1:0] sym, input logic sh, input logic pl,
                        input logic ml, input string tag);
        @(negedge clk);
        sym_in = sym; shift_en = sh; pat_load = pl; mask_load = ml;
        @(posedge clk);
        for (int i = 0; i < L; i++) begin
            if (pl) m_pat[i] = m_win[i];
            if (ml) m_msk[i] = m_win[i];
            if (sh) m_win[i] = {m_win[i][D-2:0], sym[i]};
        end
        sb.push_back(predict(tag));
    endtask

    // monitor: compares after the edge settles
    always @(negedge clk) begin
        if (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (tap_out !== e.tap || lane_hit_n !== e.hit || any_hit_n !== e.any) begin
                failures++;
                $display("FAIL %s: tap=%b hit_n=%b any=%b expected tap=%b hit_n=%b any=%b",
                         e.tag, tap_out, lane_hit_n, any_hit_n, e.tap, e.hit, e.any);
            end
        end
    end

    function automatic logic [L-1:0] pat_sym(int k);
        return L'((k * 37 + 11) ^ (k >> 2));
    endfunction

    initial begin
        for (int i = 0; i < L; i++) begin
            m_win[i] = '0; m_pat[i] = '0; m_msk[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: cleared state, every lane hits, taps low
        checks++;
        if (lane_hit_n !== '0 || any_hit_n !== 1'b0 || tap_out !== '0) begin
            failures++;
            $display("FAIL R9: hit_n=%b any=%b tap=%b expected 0 0 0", lane_hit_n, any_hit_n, tap_out);
        end
        step('0, 1'b0, 1'b0, 1'b0, "R10");

        // R1 R8: load target into the window, taps still carry zeros
        for (int k = 0; k < D; k++) step(pat_sym(k), 1'b1, 1'b0, 1'b0, "R1");
        // R4: copy window to pattern without shifting
        step('0, 1'b0, 1'b1, 1'b0, "R4");
        // R8: the target leaves through the taps 70 shifts later
        for (int k = 0; k < D; k++) step(~pat_sym(k), 1'b1, 1'b0, 1'b0, "R8");
        // R2 R7: full target again -> all lanes hit
        for (int k = 0; k < D; k++) step(pat_sym(k), 1'b1, 1'b0, 1'b0, "R2");
        // R10: hold, nothing changes
        repeat (3) step('1, 1'b0, 1'b0, 1'b0, "R10");
        // R6 R7: only lane 0 carries the target
        for (int k = 0; k < D; k++) step(pat_sym(k) ^ 7'h7E, 1'b1, 1'b0, 1'b0, "R6");
        // R7: no lane carries it -> global high
        for (int k = 0; k < D; k++) step(~pat_sym(k), 1'b1, 1'b0, 1'b0, "R7");

        // R5 R3: mask with one wildcard in lane 3 (position written at k=20)
        for (int k = 0; k < D; k++) step((k == 20) ? 7'h08 : 7'h00, 1'b1, 1'b0, 1'b0, "R5");
        step('0, 1'b0, 1'b0, 1'b1, "R5");
        // target with lane 3 flipped at that position -> lane 3 still hits
        for (int k = 0; k < D; k++) step((k == 20) ? (pat_sym(k) ^ 7'h08) : pat_sym(k), 1'b1, 1'b0, 1'b0, "R3");
        // flip another lane 3 position -> miss
        for (int k = 0; k < D; k++) step((k == 21) ? (pat_sym(k) ^ 7'h08) : pat_sym(k), 1'b1, 1'b0, 1'b0, "R3");

        // R3: lane 5 mask all ones, lanes 0..4,6 clear
        for (int k = 0; k < D; k++) step(7'h20, 1'b1, 1'b0, 1'b0, "R5");
        step('0, 1'b0, 1'b0, 1'b1, "R3");
        for (int k = 0; k < 40; k++) step(L'(k * 29 + 3), 1'b1, 1'b0, 1'b0, "R3");

        // R4 R5: load and shift in the same cycle capture pre-shift window
        step(7'h55, 1'b1, 1'b1, 1'b0, "R4");
        for (int k = 0; k < 10; k++) step(L'(k * 5), 1'b1, 1'b0, 1'b0, "R4");
        step(7'h2A, 1'b1, 1'b0, 1'b1, "R5");
        for (int k = 0; k < 20; k++) step(L'(k * 3 + 1), 1'b1, 1'b0, 1'b0, "R5");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (200000) @(posedge clk);
                failures++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule